// File: doc/BRIEF.md
# UART Transmit Holding and Shift Path

This block is the transmit side of a UART. It has two 8-bit stages: a holding register that the host loads through a simple write strobe, and a shift register that sends the character onto the serial line. Each character goes out as a low start bit, then eight data bits with the least significant bit first, then one high stop bit. A single-cycle 16x oversampling enable paces every bit. The baud divider that makes this enable sits outside the block.

The holding-empty flag goes to the host's line status register, and an optional interrupt output follows it. The flag rises when the transmitter has drained completely. It also rises at the moment a character moves from the holding register into the shifter. This lets the host queue the next character while the current one is still on the line, so frames go out back to back with no idle gap. A separate transmitter-empty output reports that the line is quiet. A sticky flag records any write that arrived while both stages were occupied.

Top module: `uart_tx_holdshift`

## Requirements
- R1: After reset, txOut is 1, holdEmpty is 1, txEmpty is 1 and wrOverrun is 0.
- R2: A write (wrEn high for one cycle) while holdEmpty is 1 loads wrData into the holding register, and holdEmpty reads 0 from the next cycle.
- R3: When the holding register is full and the shifter is idle, the character moves to the shifter on the next tick. In the cycle after that tick, holdEmpty is 1 and txOut is 0 (start bit).
- R4: A frame is one start bit of 0, then eight data bits least significant bit first, then one stop bit of 1. Each bit lasts OVERSAMPLE ticks, counted from the handoff tick. txOut changes only in the cycle after a tick.
- R5: If the holding register is full when the stop bit's last tick arrives, the next character is handed off on that same tick. Its start bit follows at once, and holdEmpty becomes 1 in that cycle.
- R6: A write while the holding register is full and the shifter is idle replaces the held character. The replaced character is never sent, and wrOverrun is not set.
- R7: A write while both the holding register and the shifter are full is ignored: the held character is sent unchanged. wrOverrun becomes 1 and stays 1 until reset.
- R8: txEmpty is 1 only when the holding register is empty and the shifter has finished its stop bit.
- R9: irqOut equals irqEn AND holdEmpty.
- R10: When no character is being shifted, txOut is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 16x oversampling enable, one cycle wide |
| wrEn | input | 1 | Host write strobe for the holding register |
| wrData | input | DATA_W | Host write data |
| irqEn | input | 1 | Enable for the holding-empty interrupt |
| txOut | output | 1 | Serial line output, idle high |
| holdEmpty | output | 1 | Holding register empty (1 = space available) |
| txEmpty | output | 1 | Both stages empty and the stop bit is complete |
| wrOverrun | output | 1 | Sticky flag: a write was dropped |
| irqOut | output | 1 | Holding-empty interrupt |

## Verification
The bench builds the block with DATA_W = 8 and OVERSAMPLE = 4, and issues a tick every third clock. This shorter bit time makes it affordable to send all 256 byte values and to check the line level before every tick of every frame. The same settings keep the back-to-back handoff, the overwrite of a pending character and the dropped write within a few hundred cycles, so the exact cycle of each holdEmpty and txOut change is checked, not only the decoded data.

// File: rtl/uart_tx_holdshift_pkg.sv
package uart_tx_holdshift_pkg;

  typedef enum logic [1:0] {
    LINE_IDLE  = 2'd0,
    LINE_START = 2'd1,
    LINE_DATA  = 2'd2,
    LINE_STOP  = 2'd3
  } lineSel_e;

  typedef struct packed {
    logic     loadHold;   // copy host data into holding register
    logic     handoff;    // move holding register into shifter
    logic     shiftData;  // advance to next data bit
    lineSel_e lineSel;    // what the serial line shows
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_holdshift_ctrl.sv
module uart_tx_holdshift_ctrl
  import uart_tx_holdshift_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      wrEn,
  output txStrobe_t strobe,
  output logic      holdEmpty,
  output logic      txEmpty,
  output logic      wrOverrun
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CNT_W      = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_DLAST = IDX_W'(DATA_W);

  logic             holdFull;
  logic             busy;
  logic             overrunQ;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;

  logic bitDone, lastBit, frameDone, shifterFree;
  logic doHandoff, doAccept, doReject;

  always_comb begin
    bitDone     = busy && tick && (tickCnt == CNT_LAST);
    lastBit     = (bitIdx == IDX_LAST);
    frameDone   = bitDone && lastBit;
    shifterFree = !busy || frameDone;
    doHandoff   = tick && holdFull && shifterFree;
    doAccept    = wrEn && (!holdFull || !busy);
    doReject    = wrEn && holdFull && busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      busy     <= 1'b0;
      overrunQ <= 1'b0;
      tickCnt  <= '0;
      bitIdx   <= '0;
    end else begin
      if (doAccept)       holdFull <= 1'b1;
      else if (doHandoff) holdFull <= 1'b0;

      if (doHandoff)      busy <= 1'b1;
      else if (frameDone) busy <= 1'b0;

      if (doReject) overrunQ <= 1'b1;

      if (doHandoff) begin
        tickCnt <= '0;
        bitIdx  <= '0;
      end else if (busy && tick) begin
        tickCnt <= bitDone ? '0 : tickCnt + 1'b1;
        if (bitDone && !lastBit) bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.loadHold  = doAccept;
    strobe.handoff   = doHandoff;
    strobe.shiftData = bitDone && (bitIdx >= IDX_FIRST) && (bitIdx <= IDX_DLAST);
    if (!busy)                  strobe.lineSel = LINE_IDLE;
    else if (bitIdx == '0)      strobe.lineSel = LINE_START;
    else if (lastBit)           strobe.lineSel = LINE_STOP;
    else                        strobe.lineSel = LINE_DATA;
  end

  assign holdEmpty = !holdFull;
  assign txEmpty   = !holdFull && !busy;
  assign wrOverrun = overrunQ;

endmodule

// File: rtl/uart_tx_holdshift_dp.sv
module uart_tx_holdshift_dp
  import uart_tx_holdshift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              txOut
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (strobe.handoff)        shiftReg <= holdReg;
      else if (strobe.shiftData) shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
      if (strobe.loadHold)       holdReg <= wrData;
    end
  end

  always_comb begin
    unique case (strobe.lineSel)
      LINE_START: txOut = 1'b0;
      LINE_DATA:  txOut = shiftReg[0];
      default:    txOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_tx_holdshift.sv
module uart_tx_holdshift
  import uart_tx_holdshift_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqEn,
  output logic              txOut,
  output logic              holdEmpty,
  output logic              txEmpty,
  output logic              wrOverrun,
  output logic              irqOut
);
  txStrobe_t strobe;

  uart_tx_holdshift_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn),
    .strobe(strobe), .holdEmpty(holdEmpty), .txEmpty(txEmpty),
    .wrOverrun(wrOverrun)
  );

  uart_tx_holdshift_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .txOut(txOut)
  );

  assign irqOut = irqEn && holdEmpty;

endmodule

// File: rtl/uart_tx_holdshift_chk.sv
module uart_tx_holdshift_chk (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic wrEn,
  input logic txOut,
  input logic holdEmpty,
  input logic txEmpty,
  input logic wrOverrun,
  input logic irqOut
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && holdEmpty) |=> !holdEmpty);

  p_line_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txOut) |-> $past(tick));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrOverrun |=> wrOverrun);

  p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrOverrun) |-> $past(wrEn && !holdEmpty));

  p_txempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty);

  p_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> holdEmpty);

  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txOut);
endmodule

bind uart_tx_holdshift uart_tx_holdshift_chk u_chk (.*);

// File: tb/uart_tx_holdshift_tb.sv
module uart_tx_holdshift_tb;
  localparam int DW = 8;
  localparam int OS = 4;
  localparam int TD = 3;
  localparam int FRAME_TICKS = (DW + 2) * OS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, tick, wrEn, irqEn;
  logic [DW-1:0] wrData;
  logic txOut, holdEmpty, txEmpty, wrOverrun, irqOut;

  uart_tx_holdshift #(.DATA_W(DW), .OVERSAMPLE(OS)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrData(wrData),
    .irqEn(irqEn), .txOut(txOut), .holdEmpty(holdEmpty), .txEmpty(txEmpty),
    .wrOverrun(wrOverrun), .irqOut(irqOut)
  );

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic expBit(input logic [DW-1:0] d, input int b);
    if (b == 0) return 1'b0;
    if (b <= DW) return d[b-1];
    return 1'b1;
  endfunction

  // all tasks start and end at a falling edge
  task automatic doWrite(input logic [DW-1:0] d);
    wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (TD - 1) @(negedge clk);
  endtask

  // line holds bit (k-1)/OS before tick k after the handoff tick
  task automatic runFrame(input logic [DW-1:0] d, input int nTicks, input string req);
    for (int k = 1; k <= nTicks; k++) begin
      logic e;
      e = expBit(d, (k - 1) / OS);
      chk(txOut == e, req, int'(txOut), int'(e));
      pulseTick();
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    rstN = 1'b0; tick = 1'b0; wrEn = 1'b0; wrData = '0; irqEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(txOut == 1'b1, "R1", int'(txOut), 1);
    chk(holdEmpty == 1'b1, "R1", int'(holdEmpty), 1);
    chk(txEmpty == 1'b1, "R1", int'(txEmpty), 1);
    chk(wrOverrun == 1'b0, "R1", int'(wrOverrun), 0);
    chk(irqOut == 1'b0, "R9", int'(irqOut), 0);
    irqEn = 1'b1;
    #1 chk(irqOut == 1'b1, "R9", int'(irqOut), 1);

    // exhaustive byte sweep: R2, R3, R4, R8, R10
    for (int v = 0; v < 256; v++) begin
      doWrite(DW'(v));
      chk(holdEmpty == 1'b0, "R2", int'(holdEmpty), 0);
      chk(txEmpty == 1'b0, "R8", int'(txEmpty), 0);
      chk(txOut == 1'b1, "R10", int'(txOut), 1);
      chk(irqOut == 1'b0, "R9", int'(irqOut), 0);
      pulseTick();
      chk(holdEmpty == 1'b1, "R3", int'(holdEmpty), 1);
      chk(txOut == 1'b0, "R3", int'(txOut), 0);
      chk(txEmpty == 1'b0, "R8", int'(txEmpty), 0);
      runFrame(DW'(v), FRAME_TICKS, "R4");
      chk(txEmpty == 1'b1, "R8", int'(txEmpty), 1);
      chk(txOut == 1'b1, "R10", int'(txOut), 1);
    end

    // R6 overwrite of pending character while shifter idle
    doWrite(8'hA5);
    doWrite(8'h3C);
    chk(wrOverrun == 1'b0, "R6", int'(wrOverrun), 0);
    pulseTick();
    chk(txOut == 1'b0, "R6", int'(txOut), 0);
    runFrame(8'h3C, FRAME_TICKS, "R6");
    chk(txEmpty == 1'b1, "R6", int'(txEmpty), 1);

    // R5 back-to-back, R7 dropped write
    doWrite(8'h96);
    pulseTick();
    doWrite(8'h5A);
    chk(holdEmpty == 1'b0, "R2", int'(holdEmpty), 0);
    chk(wrOverrun == 1'b0, "R7", int'(wrOverrun), 0);
    doWrite(8'hFF);
    chk(wrOverrun == 1'b1, "R7", int'(wrOverrun), 1);
    runFrame(8'h96, FRAME_TICKS - 1, "R4");
    chk(txOut == 1'b1, "R5", int'(txOut), 1);
    chk(holdEmpty == 1'b0, "R5", int'(holdEmpty), 0);
    pulseTick();
    chk(holdEmpty == 1'b1, "R5", int'(holdEmpty), 1);
    chk(txOut == 1'b0, "R5", int'(txOut), 0);
    chk(txEmpty == 1'b0, "R8", int'(txEmpty), 0);
    runFrame(8'h5A, FRAME_TICKS, "R7");
    chk(txEmpty == 1'b1, "R8", int'(txEmpty), 1);
    for (int k = 0; k < 2 * OS; k++) begin
      chk(txOut == 1'b1, "R7", int'(txOut), 1);
      pulseTick();
    end
    chk(wrOverrun == 1'b1, "R7", int'(wrOverrun), 1);

    irqEn = 1'b0;
    #1 chk(irqOut == 1'b0, "R9", int'(irqOut), 0);

    finish();
  end
endmodule